// File: doc/BRIEF.md
# Parallel Bus Phase Sequencer

This block runs one complete transaction on a shared parallel peripheral bus on behalf of a host. It waits for the bus to be idle and arbitrates against other devices by fixed ID priority. It then selects a target and walks through the command, data, status and message phases. Every byte in those four phases moves with a four-step request/acknowledge handshake. The responding target is modelled inside the block. It supplies the inbound data bytes, the status byte and the completion message, so a host can exercise the whole phase sequence with no external target.

The host sets a target ID, a command length, a data length and a data direction, then raises `go`. The parameters are latched when the block leaves the idle phase. Outbound bytes (command bytes and outbound data) are pulled from `host_byte`, one per `host_take` pulse. Inbound bytes appear on `rx_byte` with an `rx_valid` pulse. A `done` pulse marks the return to the idle phase. An `arb_lost` pulse marks a lost arbitration, and the block retries on its own for as long as `go` stays high.

Top module: `busphase_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the phase is idle (0), `bus_oe`, `bus_req`, `bus_ack`, `done` and `arb_lost` are low and `bus_data` is zero.
- R2: Arbitration starts only from the idle phase, one clock after `go` is high and `ext_busy` is low. While `ext_busy` is high the block stays idle and drives nothing.
- R3: The arbitration phase (1) lasts exactly one cycle. During it the block drives only bit `MY_ID` of `bus_data`, with `bus_oe` high.
- R4: If `rival_ids` has any bit above `MY_ID` set during arbitration, the block loses. It returns to idle, releases the bus and pulses `arb_lost`. Rival bits at or below `MY_ID` do not stop it from winning.
- R5: After a win, the selection phase (2) lasts one cycle and drives bit `MY_ID` OR bit `tgt_id` on `bus_data`.
- R6: Each byte takes four cycles: `bus_req` rises, `bus_ack` rises, `bus_req` falls, `bus_ack` falls. The byte is valid on `bus_data[7:0]` while `bus_ack` is high. A transfer therefore spends 2 + 4*(cmd_len + data_len + 2) cycles outside idle.
- R7: A byte phase is left only in the cycle where both `bus_req` and `bus_ack` are low.
- R8: The phases run in the order command (3), data (4), status (5), message (6), then idle. Command carries `cmd_len` bytes and data carries `data_len` bytes. A zero length skips that phase. Status carries 0x00 and the message carries 0x00 (command complete). Outbound bytes are the successive `host_byte` values, one per `host_take` pulse.
- R9: `bus_io` is 1 in the inbound phases: data when `data_in_dir` is 1, status and message. Inbound data byte k (counting from 0) is k XOR 0xA5. Each inbound byte is given on `rx_byte` with an `rx_valid` pulse in the cycle `bus_ack` rises.
- R10: When the message byte ends, `done` pulses for one cycle. In that cycle the phase is idle, `bus_oe` is low and `bus_data` is zero.
- R11: Phase codes on `phase` are idle 0, arbitration 1, selection 2, command 3, data 4, status 5, message 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Host request to run a transaction |
| ext_busy | input | 1 | Another device holds the bus |
| tgt_id | input | $clog2(BUS_W) | Target device ID |
| cmd_len | input | LEN_W | Number of command bytes |
| data_len | input | LEN_W | Number of data bytes |
| data_in_dir | input | 1 | 1: data flows target to host |
| host_byte | input | 8 | Next outbound byte from host |
| rival_ids | input | BUS_W | ID bits other devices drive in arbitration |
| phase | output | 3 | Current bus phase code |
| bus_data | output | BUS_W | Bus data lines |
| bus_oe | output | 1 | Block drives the bus |
| bus_req | output | 1 | Byte request strobe |
| bus_ack | output | 1 | Byte acknowledge strobe |
| bus_io | output | 1 | 1 when bytes flow toward the initiator |
| host_take | output | 1 | `host_byte` consumed |
| rx_valid | output | 1 | Inbound byte valid pulse |
| rx_byte | output | 8 | Inbound byte |
| done | output | 1 | Transaction complete pulse |
| arb_lost | output | 1 | Arbitration lost pulse |

## Verification
The bench builds the block with an 8-bit bus and `MY_ID` = 6. This places one device ID above the block and six below it, so both a lost arbitration (bit 7) and a win against several lower rivals are within reach. Random rival masks below bit 7, which sometimes include the block's own bit, show that only higher IDs matter. Lengths from zero upward reach every skip pattern of the command and data phases, in both data directions.

// File: rtl/busphase_pkg.sv
package busphase_pkg;
  typedef enum logic [2:0] {
    PH_FREE = 3'd0,
    PH_ARB  = 3'd1,
    PH_SEL  = 3'd2,
    PH_CMD  = 3'd3,
    PH_DATA = 3'd4,
    PH_STAT = 3'd5,
    PH_MSG  = 3'd6
  } phase_t;
endpackage

// File: rtl/busphase_arb.sv
module busphase_arb #(
  parameter int BUS_W = 8,
  parameter int MY_ID = 6
) (
  input  logic [BUS_W-1:0] rivals,
  output logic             win
);
  logic [BUS_W-1:0] hi_mask;

  for (genvar i = 0; i < BUS_W; i++) begin : g_mask
    assign hi_mask[i] = (i > MY_ID);
  end

  // only IDs above our own can beat us
  assign win = ~|(rivals & hi_mask);
endmodule

// File: rtl/busphase_hs.sv
module busphase_hs (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  output logic [1:0] step,
  output logic       req,
  output logic       ack
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      step <= 2'd0;
      req  <= 1'b0;
      ack  <= 1'b0;
    end else begin
      step <= step + 2'd1;
      case (step)
        2'd0: req <= 1'b1;
        2'd1: ack <= 1'b1;
        2'd2: req <= 1'b0;
        default: ack <= 1'b0;
      endcase
    end
  end

  a_r6_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> req);
  a_r6_req_drops_under_ack: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> ack);
endmodule

// File: rtl/busphase_ctrl.sv
module busphase_ctrl
  import busphase_pkg::*;
#(
  parameter int         BUS_W       = 8,
  parameter int         MY_ID       = 6,
  parameter int         LEN_W       = 8,
  parameter logic [7:0] TGT_PAT     = 8'hA5,
  parameter logic [7:0] STATUS_CODE = 8'h00,
  parameter logic [7:0] MSG_DONE    = 8'h00
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     go,
  input  logic                     ext_busy,
  input  logic [$clog2(BUS_W)-1:0] tgt_id,
  input  logic [LEN_W-1:0]         cmd_len,
  input  logic [LEN_W-1:0]         data_len,
  input  logic                     data_in_dir,
  input  logic [7:0]               host_byte,
  input  logic [BUS_W-1:0]         rival_ids,
  output logic [2:0]               phase,
  output logic [BUS_W-1:0]         bus_data,
  output logic                     bus_oe,
  output logic                     bus_req,
  output logic                     bus_ack,
  output logic                     bus_io,
  output logic                     host_take,
  output logic                     rx_valid,
  output logic [7:0]               rx_byte,
  output logic                     done,
  output logic                     arb_lost
);
  localparam int IDW = $clog2(BUS_W);
  localparam logic [BUS_W-1:0] ONE = {{(BUS_W-1){1'b0}}, 1'b1};
  localparam logic [BUS_W-1:0] OWN_BIT = ONE << MY_ID;

  phase_t           ph_q;
  logic [LEN_W-1:0] cnt_q, clen_q, dlen_q;
  logic             dir_q;
  logic [IDW-1:0]   tgt_q;
  logic [BUS_W-1:0] data_q;
  logic             oe_q, io_q, take_q, rxv_q, done_q, lost_q;
  logic [7:0]       rxb_q;

  logic             win, run, inbound, last;
  logic [1:0]       st;
  logic             hs_req, hs_ack;
  logic [LEN_W-1:0] cur_len;
  logic [BUS_W-1:0] in_word, host_word;
  phase_t           first_ph, after_ph;

  function automatic logic inbound_of(phase_t p, logic dir);
    return (p == PH_DATA && dir) || p == PH_STAT || p == PH_MSG;
  endfunction

  busphase_arb #(.BUS_W(BUS_W), .MY_ID(MY_ID)) u_arb (
    .rivals(rival_ids),
    .win   (win)
  );

  assign run = (ph_q == PH_CMD) || (ph_q == PH_DATA) ||
               (ph_q == PH_STAT) || (ph_q == PH_MSG);

  busphase_hs u_hs (
    .clk (clk),
    .rst (rst),
    .run (run),
    .step(st),
    .req (hs_req),
    .ack (hs_ack)
  );

  always_comb begin
    inbound   = inbound_of(ph_q, dir_q);
    cur_len   = (ph_q == PH_CMD)  ? clen_q :
                (ph_q == PH_DATA) ? dlen_q : {{(LEN_W-1){1'b0}}, 1'b1};
    last      = (cnt_q == cur_len - {{(LEN_W-1){1'b0}}, 1'b1});
    first_ph  = (clen_q != '0) ? PH_CMD : (dlen_q != '0) ? PH_DATA : PH_STAT;
    case (ph_q)
      PH_CMD:  after_ph = (dlen_q != '0) ? PH_DATA : PH_STAT;
      PH_DATA: after_ph = PH_STAT;
      PH_STAT: after_ph = PH_MSG;
      default: after_ph = PH_FREE;
    endcase
    in_word   = '0;
    host_word = '0;
    host_word[7:0] = host_byte;
    case (ph_q)
      PH_DATA: in_word[7:0] = 8'(cnt_q) ^ TGT_PAT;
      PH_STAT: in_word[7:0] = STATUS_CODE;
      default: in_word[7:0] = MSG_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_FREE;
      cnt_q  <= '0;
      clen_q <= '0;
      dlen_q <= '0;
      dir_q  <= 1'b0;
      tgt_q  <= '0;
      data_q <= '0;
      oe_q   <= 1'b0;
      io_q   <= 1'b0;
      take_q <= 1'b0;
      rxv_q  <= 1'b0;
      rxb_q  <= '0;
      done_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      take_q <= 1'b0;
      rxv_q  <= 1'b0;
      done_q <= 1'b0;
      lost_q <= 1'b0;
      case (ph_q)
        PH_FREE: begin
          if (go && !ext_busy) begin
            clen_q <= cmd_len;
            dlen_q <= data_len;
            dir_q  <= data_in_dir;
            tgt_q  <= tgt_id;
            data_q <= OWN_BIT;
            oe_q   <= 1'b1;
            ph_q   <= PH_ARB;
          end
        end
        PH_ARB: begin
          if (win) begin
            data_q <= OWN_BIT | (ONE << tgt_q);
            ph_q   <= PH_SEL;
          end else begin
            data_q <= '0;
            oe_q   <= 1'b0;
            lost_q <= 1'b1;
            ph_q   <= PH_FREE;
          end
        end
        PH_SEL: begin
          ph_q  <= first_ph;
          io_q  <= inbound_of(first_ph, dir_q);
          cnt_q <= '0;
        end
        default: begin
          case (st)
            2'd0: begin
              data_q <= inbound ? in_word : host_word;
              take_q <= !inbound;
            end
            2'd1: begin
              if (inbound) begin
                rxv_q <= 1'b1;
                rxb_q <= data_q[7:0];
              end
            end
            2'd3: begin
              if (last) begin
                cnt_q <= '0;
                ph_q  <= after_ph;
                io_q  <= inbound_of(after_ph, dir_q);
                if (ph_q == PH_MSG) begin
                  oe_q   <= 1'b0;
                  data_q <= '0;
                  done_q <= 1'b1;
                end
              end else begin
                cnt_q <= cnt_q + {{(LEN_W-1){1'b0}}, 1'b1};
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assign phase     = ph_q;
  assign bus_data  = data_q;
  assign bus_oe    = oe_q;
  assign bus_req   = hs_req;
  assign bus_ack   = hs_ack;
  assign bus_io    = io_q;
  assign host_take = take_q;
  assign rx_valid  = rxv_q;
  assign rx_byte   = rxb_q;
  assign done      = done_q;
  assign arb_lost  = lost_q;

  a_r2_wait_while_busy: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FREE && ext_busy) |=> (ph_q == PH_FREE));
  a_r3_single_id_bit: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ARB) |-> ($countones(bus_data) == 1 && bus_oe));
  a_r4_lose_to_higher: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ARB && !win) |=> (ph_q == PH_FREE && arb_lost && !bus_oe));
  a_r4_win_selects: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ARB && win) |=> (ph_q == PH_SEL));
  a_r7_change_when_idle: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && ph_q != $past(ph_q)) |-> (!bus_req && !bus_ack));
  a_r10_release_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (ph_q == PH_FREE && !bus_oe && bus_data == '0));
endmodule

// File: tb/busphase_ctrl_bench.sv
module busphase_ctrl_bench;
  localparam int BW = 8;
  localparam int ME = 6;
  localparam int LW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst = 1'b1, go = 1'b0, ext_busy = 1'b0, data_in_dir = 1'b0;
  logic [2:0]    tgt_id = '0;
  logic [LW-1:0] cmd_len = '0, data_len = '0;
  logic [7:0]    host_byte;
  logic [BW-1:0] rival_ids = '0;
  logic [2:0]    phase;
  logic [BW-1:0] bus_data;
  logic          bus_oe, bus_req, bus_ack, bus_io, host_take, rx_valid, done, arb_lost;
  logic [7:0]    rx_byte;

  busphase_ctrl #(.BUS_W(BW), .MY_ID(ME), .LEN_W(LW)) u_busphase_ctrl (
    .clk(clk), .rst(rst), .go(go), .ext_busy(ext_busy), .tgt_id(tgt_id),
    .cmd_len(cmd_len), .data_len(data_len), .data_in_dir(data_in_dir),
    .host_byte(host_byte), .rival_ids(rival_ids), .phase(phase),
    .bus_data(bus_data), .bus_oe(bus_oe), .bus_req(bus_req), .bus_ack(bus_ack),
    .bus_io(bus_io), .host_take(host_take), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .done(done), .arb_lost(arb_lost)
  );

  int checks = 0, errors = 0, ncyc = 0, hcnt = 0, eh = 0;

  function automatic logic [7:0] hb(int n);
    return 8'(n * 37 + 11);
  endfunction

  initial host_byte = hb(0);
  always @(negedge clk) begin
    if (rst) begin
      hcnt = 0;
      host_byte = hb(0);
    end else if (host_take) begin
      hcnt++;
      host_byte = hb(hcnt);
    end
  end

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic run_xfer(int t, int c, int d, bit din, logic [BW-1:0] riv);
    int exps[8];
    int ne = 0, idx = 0, cyc = 0, kin = 0, guard = 0;
    logic [2:0] pph = 3'd0;
    logic pack = 1'b0;
    bit fin = 0;
    bit inb;
    logic [7:0] expb;
    exps[ne++] = 1; exps[ne++] = 2;
    if (c != 0) exps[ne++] = 3;
    if (d != 0) exps[ne++] = 4;
    exps[ne++] = 5; exps[ne++] = 6; exps[ne++] = 0;
    @(negedge clk);
    tgt_id = 3'(t); cmd_len = LW'(c); data_len = LW'(d);
    data_in_dir = din; rival_ids = riv; go = 1'b1;
    while (!fin && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (phase != 3'd0) cyc++;
      if (phase == 3'd1) go = 1'b0;
      if (phase != pph) begin
        chk(idx < ne && int'(phase) == exps[idx], "R8/R11 phase order", phase,
            idx < ne ? exps[idx] : -1);
        idx++;
        if (pph >= 3'd3) chk(!bus_req && !bus_ack, "R7 handshake idle at change",
                             {bus_req, bus_ack}, 0);
      end
      if (phase == 3'd1)
        chk(bus_data == (BW'(1) << ME) && bus_oe, "R3 own id bit", bus_data, 1 << ME);
      if (phase == 3'd2)
        chk(bus_data == ((BW'(1) << ME) | (BW'(1) << t)), "R5 selection bits",
            bus_data, (1 << ME) | (1 << t));
      if (bus_ack && !pack) begin
        chk(bus_req, "R6 ack raised under req", bus_req, 1);
        inb = (phase == 3'd5) || (phase == 3'd6) || (phase == 3'd4 && din);
        chk(bus_io == inb, "R9 direction", bus_io, inb);
        if (phase == 3'd3 || (phase == 3'd4 && !din)) begin
          expb = hb(eh); eh++;
        end else if (phase == 3'd4) begin
          expb = 8'(kin) ^ 8'hA5; kin++;
        end else expb = 8'h00;
        chk(bus_data[7:0] == expb, "R8 byte on bus", bus_data[7:0], expb);
        if (inb) chk(rx_valid && rx_byte == expb, "R9 received byte", rx_byte, expb);
        else     chk(!rx_valid, "R9 no rx on outbound", rx_valid, 0);
      end
      pack = bus_ack;
      pph = phase;
      if (done) begin
        fin = 1;
        chk(phase == 3'd0 && !bus_oe && bus_data == '0, "R10 release at done",
            {phase, bus_oe}, 0);
        chk(cyc == 2 + 4 * (c + d + 2), "R6 transfer cycle count", cyc,
            2 + 4 * (c + d + 2));
        chk(idx == ne, "R8 all phases seen", idx, ne);
      end
    end
    if (!fin) chk(0, "R8 transfer never completed", 0, 1);
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && !bus_oe && !bus_req && !bus_ack && bus_data == '0 && !done &&
        !arb_lost, "R1 reset state", phase, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !bus_oe, "R1 idle after reset", phase, 0);

    // bus held by another device, and a higher rival waiting
    rival_ids = 8'h80; ext_busy = 1'b1; go = 1'b1;
    repeat (4) @(negedge clk);
    chk(phase == 3'd0 && !bus_oe, "R2 held off by busy bus", phase, 0);
    ext_busy = 1'b0;
    @(negedge clk);
    chk(phase == 3'd1, "R2 arbitration after free", phase, 1);
    chk(bus_data == 8'h40, "R3 arbitration id", bus_data, 8'h40);
    @(negedge clk);
    chk(phase == 3'd0 && arb_lost && !bus_oe && bus_data == '0, "R4 lost to higher id",
        {phase, arb_lost}, 1);
    go = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !arb_lost, "R4 no retry without go", phase, 0);

    // directed corner cases, lower rivals and own bit present
    run_xfer(2, 1, 0, 1'b0, 8'h3F);
    run_xfer(0, 0, 0, 1'b0, 8'h7F);
    run_xfer(7, 3, 4, 1'b1, 8'h01);
    run_xfer(5, 2, 3, 1'b0, 8'h00);
    run_xfer(1, 0, 2, 1'b1, 8'h20);

    for (int i = 0; i < 20; i++) begin
      int t;
      t = int'($urandom_range(7, 0));
      if (t == ME) t = 3;
      run_xfer(t, int'($urandom_range(4, 0)), int'($urandom_range(5, 0)),
               1'($urandom_range(1, 0)), BW'($urandom) & 8'h7F);
    end
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule